// File: doc/BRIEF.md
# Lock-Gated Synchronous ROM Guard

This block wraps a pre-initialised synchronous memory that serves as read-only storage and keeps its contents safe from address-setup violations. Holding the write side inactive does not protect such an array; only a low memory enable does. The block therefore drives the array enable from a small controller. The enable is high only once the clock source has reported lock and has then stayed locked for a programmable settling period. It is pulled low before a planned change of clock source. Any unplanned loss of lock while reads are running is treated as possible damage to the contents, and a sticky flag reports it.

The controller moves through six named states. ST_RESET is left on the first edge after reset and leads to ST_WAIT_LOCK. ST_WAIT_LOCK leads to ST_SETTLE when lock is seen. ST_SETTLE leads to ST_RUN after SETTLE_CYC locked cycles, or back to ST_WAIT_LOCK if lock drops. ST_RUN leads to ST_FAULT on loss of lock, or to ST_SWITCH_HOLD on a switch request. ST_SWITCH_HOLD leads to ST_SETTLE once it has acknowledged, the request is withdrawn and lock is present. ST_FAULT is left only by reset. The enable is high in ST_RUN alone. A read is captured into an address register on a clock edge, and the array is read from that register on the next edge, so the array only ever sees an address that has been stable for a full cycle.

Top module: `rom_guard`

## Requirements
- R1: Word a of the array holds the low DATA_W bits of (a × 40503) XOR 0x5A5A. A read request sampled with the enable high at edge E gives rd_valid_o high for exactly one cycle after edge E+1, with rd_data_o equal to that word.
- R2: Read requests on consecutive cycles each produce their own strobe on consecutive cycles, in request order.
- R3: After the asynchronous reset, mem_en_o stays low. It goes high on the (SETTLE_CYC+1)-th rising edge that samples lock_i high, counted from the first such edge in ST_WAIT_LOCK: one edge to enter ST_SETTLE and SETTLE_CYC edges inside it.
- R4: A low lock_i during ST_SETTLE returns the block to ST_WAIT_LOCK without setting corrupt_o. The next settling period starts again from zero.
- R5: sw_req_i sampled high in ST_RUN with lock present makes mem_en_o low from the next edge. A read that was captured but not yet performed is dropped and gives no strobe.
- R6: sw_ack_o rises one edge after ST_SWITCH_HOLD is entered and stays high until exit. Exit happens on an edge with sw_ack_o high, sw_req_i low and lock_i high. It leads to ST_SETTLE with sw_ack_o low, followed by a full settling period.
- R7: lock_i sampled low in ST_RUN moves the block to ST_FAULT and sets corrupt_o with mem_en_o low from the next edge. A lock loss in ST_SWITCH_HOLD or ST_SETTLE does not set corrupt_o.
- R8: corrupt_o stays high until reset clears it, and reset clears it asynchronously. Once lock returns, ST_FAULT still keeps mem_en_o low. rd_valid_o is never high while corrupt_o is high, including for a read already captured when lock was lost.
- R9: A read request while mem_en_o is low is ignored. It produces no strobe and leaves the captured address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Clock source reports lock |
| sw_req_i | input | 1 | Planned clock-source change requested |
| sw_ack_o | output | 1 | Enable dropped; clock source may be switched |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data |
| rd_valid_o | output | 1 | Read data valid, one cycle per read |
| mem_en_o | output | 1 | Guarded array enable |
| corrupt_o | output | 1 | Sticky flag: lock lost while enabled |

## Verification
The bench counts the settling period to the exact edge, both the first time and after an interrupted settle. A controller off by one would raise the enable a cycle early or late, and one that does not restart its counter would finish early. It issues a read in the same cycle as a switch request, and another read just before lock is lost. A design that read from the array after dropping the enable, or that let the in-flight read through after the fault, would produce a strobe the scoreboard has no entry for. It also drops lock in the middle of a switch to confirm no false fault, and checks that reads sent while the enable is low, and lock returning after a fault, leave the block disabled until reset.

// File: rtl/rom_guard_pkg.sv
package rom_guard_pkg;

    typedef enum logic [2:0] {
        ST_RESET       = 3'd0,
        ST_WAIT_LOCK   = 3'd1,
        ST_SETTLE      = 3'd2,
        ST_RUN         = 3'd3,
        ST_SWITCH_HOLD = 3'd4,
        ST_FAULT       = 3'd5
    } guard_state_e;

    // Initial array contents, computed rather than tabulated.
    function automatic logic [31:0] rom_word(input int unsigned a);
        return (a * 32'd40503) ^ 32'h0000_5A5A;
    endfunction

endpackage

// File: rtl/rom_guard_ctrl.sv
module rom_guard_ctrl
    import rom_guard_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    input  logic sw_req_i,
    output logic mem_en_o,
    output logic sw_ack_o,
    output logic corrupt_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    guard_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             ack_q;
    logic             corrupt_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:       state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK:   if (lock_i) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!lock_i)                state_d = ST_WAIT_LOCK;
                else if (cnt_q == CNT_LAST) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!lock_i)       state_d = ST_FAULT;
                else if (sw_req_i) state_d = ST_SWITCH_HOLD;
            end
            ST_SWITCH_HOLD: if (ack_q && !sw_req_i && lock_i) state_d = ST_SETTLE;
            ST_FAULT:       state_d = ST_FAULT;
            default:        state_d = ST_RESET;
        endcase
    end

    // State register and settle counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE && state_d == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                                              cnt_q <= '0;
        end
    end

    // Registered outputs: acknowledge and sticky corruption flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            corrupt_q <= 1'b0;
        end else begin
            ack_q <= (state_q == ST_SWITCH_HOLD) && (state_d == ST_SWITCH_HOLD);
            if (state_q == ST_RUN && !lock_i) corrupt_q <= 1'b1;
        end
    end

    always_comb begin
        mem_en_o  = (state_q == ST_RUN);
        sw_ack_o  = ack_q;
        corrupt_o = corrupt_q;
    end

    AST_EN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_o) |-> ($past(state_q) == ST_SETTLE && $past(lock_i))); // R3
    AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !lock_i) |=> (state_q == ST_WAIT_LOCK && !corrupt_o)); // R4
    AST_SWITCH_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && lock_i && sw_req_i) |=> !mem_en_o); // R5
    AST_ACK_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ack_o) |-> ($past(state_q) == ST_SWITCH_HOLD && state_q == ST_SWITCH_HOLD)); // R6
    AST_LOSS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !lock_i) |=> (corrupt_o && !mem_en_o)); // R7
    AST_CORRUPT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        corrupt_o |=> corrupt_o); // R8

endmodule

// File: rtl/rom_guard_rdpath.sv
module rom_guard_rdpath #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic              pend_q
);
    // The address is captured only on an edge with the enable high, so
    // the array always sees an address held for a whole cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= mem_en_i && rd_req_i;
            if (mem_en_i && rd_req_i) addr_q <= rd_addr_i;
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en_i |=> $stable(addr_q)); // R9

endmodule

// File: rtl/rom_guard_array.sv
module rom_guard_array
    import rom_guard_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_init
        assign mem[i] = DATA_W'(rom_word(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= en_i;
            if (en_i) data_o <= mem[addr_i];
        end
    end

endmodule

// File: rtl/rom_guard.sv
module rom_guard #(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              sw_req_i,
    output logic              sw_ack_o,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              mem_en_o,
    output logic              corrupt_o
);
    logic              mem_en;
    logic              corrupt;
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q;
    logic              arr_valid;

    rom_guard_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (lock_i),
        .sw_req_i  (sw_req_i),
        .mem_en_o  (mem_en),
        .sw_ack_o  (sw_ack_o),
        .corrupt_o (corrupt)
    );

    rom_guard_rdpath #(.ADDR_W(ADDR_W)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en_i  (mem_en),
        .rd_req_i  (rd_req_i),
        .rd_addr_i (rd_addr_i),
        .addr_q    (addr_q),
        .pend_q    (pend_q)
    );

    // The array enable is the guarded enable qualified by a captured read.
    rom_guard_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mem_en && pend_q),
        .addr_i  (addr_q),
        .data_o  (rd_data_o),
        .valid_o (arr_valid)
    );

    assign rd_valid_o = arr_valid && !corrupt;
    assign mem_en_o   = mem_en;
    assign corrupt_o  = corrupt;

    AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_req_i, 2)); // R1

endmodule

// File: tb/rom_guard_test.sv
module rom_guard_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_i = 1'b0, sw_req_i = 1'b0, rd_req_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          rd_valid_o, mem_en_o, corrupt_o, sw_ack_o;

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    rom_guard #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(N)) uut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .sw_req_i(sw_req_i),
        .sw_ack_o(sw_ack_o), .rd_req_i(rd_req_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .mem_en_o(mem_en_o),
        .corrupt_o(corrupt_o)
    );

    function automatic logic [DW-1:0] exp_word(input int a);
        return DW'((a * 40503) ^ 32'h5A5A);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one request per call, advances one negedge.
    task automatic issue_read(input int a, input bit expect_data);
        rd_addr_i = AW'(a);
        rd_req_i  = 1'b1;
        if (expect_data) exp_q.push_back(exp_word(a));
        @(negedge clk);
        rd_req_i  = 1'b0;
    endtask

    // Checks the enable rises exactly after `rem` further edges.
    task automatic settle_count(input int rem, input string tag);
        for (int k = 0; k < rem - 1; k++) begin
            @(negedge clk);
            chk(mem_en_o == 1'b0, tag, mem_en_o, 0);
        end
        @(negedge clk);
        chk(mem_en_o == 1'b1, tag, mem_en_o, 1);
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9/R8/R5 unexpected strobe", 1, 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data_o == e, "R1 read data", rd_data_o, e);
            end
        end
    end

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(mem_en_o == 0 && corrupt_o == 0 && rd_valid_o == 0 && sw_ack_o == 0,
            "R3 reset state", {mem_en_o, corrupt_o, rd_valid_o, sw_ack_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        issue_read(4, 0);                                   // R9 ignored while waiting
        chk(mem_en_o == 0, "R3 enable low without lock", mem_en_o, 0);

        // Interrupted settle: R4
        lock_i = 1'b1;
        repeat (5) @(negedge clk);
        lock_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_en_o == 0 && corrupt_o == 0, "R4 settle interrupted", {mem_en_o, corrupt_o}, 0);
        lock_i = 1'b1;
        settle_count(N + 1, "R3 settle length");

        // Reads: R1 single, R2 back-to-back
        issue_read(0, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 single read delivered", exp_q.size(), 0);
        issue_read(63, 1);
        issue_read(5, 1);
        issue_read(5, 1);
        issue_read(42, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 burst delivered", exp_q.size(), 0);

        // Planned switch with read in the same cycle: R5, R6
        rd_addr_i = 7; rd_req_i = 1'b1; sw_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        chk(mem_en_o == 0, "R5 enable dropped", mem_en_o, 0);
        chk(sw_ack_o == 0, "R6 ack not yet", sw_ack_o, 0);
        @(negedge clk);
        chk(sw_ack_o == 1, "R6 ack one edge later", sw_ack_o, 1);
        chk(rd_valid_o == 0, "R5 in-flight read dropped", rd_valid_o, 0);
        issue_read(3, 0);                                   // R9 ignored during hold
        lock_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(corrupt_o == 0, "R7 no fault during hold", corrupt_o, 0);
        chk(sw_ack_o == 1, "R6 ack held", sw_ack_o, 1);
        lock_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_en_o == 0, "R6 hold while request high", mem_en_o, 0);
        sw_req_i = 1'b0;
        @(negedge clk);
        chk(sw_ack_o == 0, "R6 ack cleared on exit", sw_ack_o, 0);
        settle_count(N, "R6 resettle length");
        issue_read(9, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 reads restored", exp_q.size(), 0);

        // Unexpected loss with read in flight: R7, R8
        issue_read(11, 0);
        lock_i = 1'b0;
        @(negedge clk);
        chk(corrupt_o == 1 && mem_en_o == 0, "R7 fault on loss", {corrupt_o, mem_en_o}, 2);
        chk(rd_valid_o == 0, "R8 no strobe in fault", rd_valid_o, 0);
        lock_i = 1'b1;
        repeat (N + 5) @(negedge clk);
        issue_read(12, 0);
        repeat (3) @(negedge clk);
        chk(corrupt_o == 1 && mem_en_o == 0, "R8 fault sticky", {corrupt_o, mem_en_o}, 2);
        #2 rst_n = 1'b0;
        #1;
        chk(corrupt_o == 0, "R8 async reset clears", corrupt_o, 0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule